// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic read-modify-write operation on a single-port synchronous memory on behalf of a processor core. A request names an operation, a word address and two register operands. The operands are a source, which may be a low/high pair, and a comparand or accumulator, which may also be a low/high pair. The block reads the memory, works out the new memory contents and the new register values, writes back when the operation calls for it, and reports status flags.

While a sequence runs, a bus lock output is held. It rises with the first read and stays high through the final write and the done cycle, so no other master can reach the memory between the read and the write. Four operations are supported. A plain swap and a swap-with-add work on one word. A compare-and-swap works either on one word or on a two-word value held at two consecutive addresses.

The memory returns read data one cycle after a read is issued. The surrounding core starts an operation with a one-cycle `start` pulse. It takes the register results and flags when `done` is high.

Top module: `atomic_rmw_unit`

## Requirements
- R1: During and straight after reset, `busLock`, `done`, `memEn` and `memWe` are low, and `srcOut`, `cmpOutLo`, `cmpOutHi` and all four flags are zero.
- R2: Operation code 0 (swap) writes `srcLo` to the word at `addr` and returns the word's old value on `srcOut`. The comparand outputs echo `cmpLo` and `cmpHi`, and the four flags keep their previous values.
- R3: Operation code 1 (swap-with-add) writes the 32-bit sum of `srcLo` and the old word to `addr` and returns the old word on `srcOut`. It sets the flags from that addition: carry is the carry-out, zero marks a zero sum, sign is sum bit 31, and overflow marks signed overflow.
- R4: Operation code 2 (single-word compare-and-swap) with `cmpLo` equal to the word writes `srcLo` to `addr`. `cmpOutLo` returns the old word and `srcOut` echoes `srcLo`.
- R5: Operation code 2 with `cmpLo` different from the word leaves memory untouched and loads the old word into `cmpOutLo`. In both the R4 and R5 cases, the flags are those of `cmpLo` minus the old word: carry is the borrow, plus zero, sign and signed overflow of the difference.
- R6: Operation code 3 (double compare-and-swap) compares `{cmpHi,cmpLo}` with `{word[addr+1],word[addr]}`, where the address wraps modulo the address space. On a match it writes `srcLo` to `addr` and `srcHi` to `addr+1`. On a mismatch it writes nothing. In both cases `cmpOutHi`/`cmpOutLo` return the old pair, only the zero flag changes (set on a match), and the other three flags keep their values.
- R7: `busLock` rises in the cycle of the first memory access, which is a read at `addr`. It stays high through every access and the `done` cycle, and it falls in the cycle after `done`. No memory access happens while it is low.
- R8: `done` is a one-cycle pulse. Counted in cycles after the clock edge that accepts `start`, it comes in cycle 4 for swap, swap-with-add and a matching single compare. It comes in cycle 3 for a single-word mismatch, cycle 6 for a two-word match and cycle 4 for a two-word mismatch.
- R9: A `start` pulse that arrives while an operation is in progress is ignored. No second operation follows, and the running one completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| opCode | input | 2 | 0 swap, 1 swap-with-add, 2 compare-and-swap, 3 double compare-and-swap |
| addr | input | ADDR_W | Word address of the memory operand |
| srcLo | input | DATA_W | Source register (low word of the replacement pair) |
| srcHi | input | DATA_W | High word of the replacement pair |
| cmpLo | input | DATA_W | Comparand register (low word of the comparand pair) |
| cmpHi | input | DATA_W | High word of the comparand pair |
| memRdata | input | DATA_W | Read data, valid one cycle after a read |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| busLock | output | 1 | Held for the whole read-then-write sequence |
| done | output | 1 | One-cycle completion pulse |
| srcOut | output | DATA_W | New source register value |
| cmpOutLo | output | DATA_W | New comparand low register value |
| cmpOutHi | output | DATA_W | New comparand high register value |
| flagCarry | output | 1 | Carry / borrow flag |
| flagZero | output | 1 | Zero flag |
| flagSign | output | 1 | Sign flag |
| flagOvf | output | 1 | Signed overflow flag |

## Verification
Each operation runs on random memory contents and random operands. The compare forms get the comparand copied from memory about half the time, so that matches and mismatches both occur often and each exercises its own write path and cycle count. Directed cases cover operands the random draw seldom produces. A sum that overflows the signed range separates the overflow flag from carry. A sum that wraps to zero sets both carry and zero. A comparand below the memory word forces a borrow. A two-word comparand that differs only in its high word shows that the high word is actually compared. A pair at the last address shows the address wrapping. A swap after a flag-setting operation shows that the flags are held. A start pulse injected mid-sequence, compared against the whole memory afterwards, separates ignored requests from a second operation.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

  typedef enum logic [1:0] {
    OP_SWAP  = 2'd0,
    OP_XADD  = 2'd1,
    OP_CAS   = 2'd2,
    OP_CAS2W = 2'd3
  } atomicOp_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_WRITE,
    ST_DONE
  } seqState_t;

  // strobes from the control sequencer to the datapath
  typedef struct packed {
    logic load;     // latch request operands
    logic memEn;    // drive a memory access
    logic memWe;    // access is a write
    logic wordIdx;  // 0: addr, 1: addr+1
    logic capLo;    // capture low word of a two-word read
    logic evalNow;  // read data complete, compute results
  } ctrlStrobes_t;

endpackage

// File: rtl/atomic_ctrl.sv
module atomic_ctrl
  import atomic_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   opCode,
  input  logic         matchNow,
  output ctrlStrobes_t strb,
  output logic         busLock,
  output logic         done
);

  seqState_t state, stateNext;
  atomicOp_t opReg;
  logic      idxReg, idxNext;
  logic      isWide, isCompare;

  assign isWide    = (opReg == OP_CAS2W);
  assign isCompare = (opReg == OP_CAS) || (opReg == OP_CAS2W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opReg  <= OP_SWAP;
      idxReg <= 1'b0;
    end else begin
      state  <= stateNext;
      idxReg <= idxNext;
      if (state == ST_IDLE && start) opReg <= atomicOp_t'(opCode);
    end
  end

  always_comb begin
    stateNext = state;
    idxNext   = idxReg;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          idxNext   = 1'b0;
          stateNext = ST_READ;
        end
      end
      ST_READ: begin
        strb.memEn   = 1'b1;
        strb.wordIdx = idxReg;
        strb.capLo   = idxReg;
        if (isWide && !idxReg) begin
          idxNext = 1'b1;
        end else begin
          idxNext   = 1'b0;
          stateNext = ST_EVAL;
        end
      end
      ST_EVAL: begin
        strb.evalNow = 1'b1;
        idxNext      = 1'b0;
        stateNext    = (isCompare && !matchNow) ? ST_DONE : ST_WRITE;
      end
      ST_WRITE: begin
        strb.memEn   = 1'b1;
        strb.memWe   = 1'b1;
        strb.wordIdx = idxReg;
        if (isWide && !idxReg) begin
          idxNext = 1'b1;
        end else begin
          idxNext   = 1'b0;
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busLock = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

endmodule

// File: rtl/atomic_datapath.sv
module atomic_datapath
  import atomic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [1:0]        opCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] srcLo,
  input  logic [DATA_W-1:0] srcHi,
  input  logic [DATA_W-1:0] cmpLo,
  input  logic [DATA_W-1:0] cmpHi,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              matchNow,
  output logic [DATA_W-1:0] srcOut,
  output logic [DATA_W-1:0] cmpOutLo,
  output logic [DATA_W-1:0] cmpOutHi,
  output logic              flagCarry,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagOvf
);

  localparam int MSB = DATA_W - 1;

  atomicOp_t         opReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] srcLoReg, srcHiReg, cmpLoReg, cmpHiReg;
  logic [DATA_W-1:0] oldLoReg, wrLoReg;
  logic [DATA_W-1:0] memNowLo, memNowHi;
  logic [DATA_W:0]   sumExt, diffExt;
  logic [DATA_W-1:0] sumVal, diffVal;
  logic              sumOvf, diffOvf;

  // operand latches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg    <= OP_SWAP;
      addrReg  <= '0;
      srcLoReg <= '0;
      srcHiReg <= '0;
      cmpLoReg <= '0;
      cmpHiReg <= '0;
    end else if (strb.load) begin
      opReg    <= atomicOp_t'(opCode);
      addrReg  <= addr;
      srcLoReg <= srcLo;
      srcHiReg <= srcHi;
      cmpLoReg <= cmpLo;
      cmpHiReg <= cmpHi;
    end
  end

  // low word of a two-word read arrives one cycle before the high word
  always_ff @(posedge clk) begin
    if (!rstN)           oldLoReg <= '0;
    else if (strb.capLo) oldLoReg <= memRdata;
  end

  assign memNowLo = (opReg == OP_CAS2W) ? oldLoReg : memRdata;
  assign memNowHi = memRdata;

  assign sumExt  = {1'b0, srcLoReg} + {1'b0, memNowLo};
  assign diffExt = {1'b0, cmpLoReg} - {1'b0, memNowLo};
  assign sumVal  = sumExt[MSB:0];
  assign diffVal = diffExt[MSB:0];
  assign sumOvf  = (srcLoReg[MSB] == memNowLo[MSB]) && (sumVal[MSB] != srcLoReg[MSB]);
  assign diffOvf = (cmpLoReg[MSB] != memNowLo[MSB]) && (diffVal[MSB] != cmpLoReg[MSB]);

  always_comb begin
    unique case (opReg)
      OP_CAS:   matchNow = (cmpLoReg == memNowLo);
      OP_CAS2W: matchNow = ({cmpHiReg, cmpLoReg} == {memNowHi, memNowLo});
      default:  matchNow = 1'b1;
    endcase
  end

  // result registers, updated once per operation in the evaluate cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcOut    <= '0;
      cmpOutLo  <= '0;
      cmpOutHi  <= '0;
      wrLoReg   <= '0;
      flagCarry <= 1'b0;
      flagZero  <= 1'b0;
      flagSign  <= 1'b0;
      flagOvf   <= 1'b0;
    end else if (strb.evalNow) begin
      srcOut   <= srcLoReg;
      cmpOutLo <= cmpLoReg;
      cmpOutHi <= cmpHiReg;
      wrLoReg  <= srcLoReg;
      unique case (opReg)
        OP_SWAP: begin
          srcOut <= memNowLo;
        end
        OP_XADD: begin
          srcOut    <= memNowLo;
          wrLoReg   <= sumVal;
          flagCarry <= sumExt[DATA_W];
          flagZero  <= (sumVal == '0);
          flagSign  <= sumVal[MSB];
          flagOvf   <= sumOvf;
        end
        OP_CAS: begin
          cmpOutLo  <= memNowLo;
          flagCarry <= diffExt[DATA_W];
          flagZero  <= (diffVal == '0);
          flagSign  <= diffVal[MSB];
          flagOvf   <= diffOvf;
        end
        OP_CAS2W: begin
          cmpOutLo <= memNowLo;
          cmpOutHi <= memNowHi;
          flagZero <= matchNow;
        end
        default: ;
      endcase
    end
  end

  assign memAddr  = addrReg + ADDR_W'(strb.wordIdx);
  assign memWdata = strb.wordIdx ? srcHiReg : wrLoReg;

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] srcLo,
  input  logic [DATA_W-1:0] srcHi,
  input  logic [DATA_W-1:0] cmpLo,
  input  logic [DATA_W-1:0] cmpHi,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              busLock,
  output logic              done,
  output logic [DATA_W-1:0] srcOut,
  output logic [DATA_W-1:0] cmpOutLo,
  output logic [DATA_W-1:0] cmpOutHi,
  output logic              flagCarry,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagOvf
);

  ctrlStrobes_t strb;
  logic         matchNow;

  atomic_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opCode   (opCode),
    .matchNow (matchNow),
    .strb     (strb),
    .busLock  (busLock),
    .done     (done)
  );

  atomic_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opCode    (opCode),
    .addr      (addr),
    .srcLo     (srcLo),
    .srcHi     (srcHi),
    .cmpLo     (cmpLo),
    .cmpHi     (cmpHi),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .matchNow  (matchNow),
    .srcOut    (srcOut),
    .cmpOutLo  (cmpOutLo),
    .cmpOutHi  (cmpOutHi),
    .flagCarry (flagCarry),
    .flagZero  (flagZero),
    .flagSign  (flagSign),
    .flagOvf   (flagOvf)
  );

  assign memEn = strb.memEn;
  assign memWe = strb.memWe;

endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker (
  input logic clk,
  input logic rstN,
  input logic busLock,
  input logic done,
  input logic memEn,
  input logic memWe
);

  // R7: every memory access happens under the lock
  a_r7_access_locked: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> busLock);

  // R7: lock still held in the done cycle
  a_r7_done_locked: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busLock);

  // R7: lock falls the cycle after done
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busLock);

  // R7: lock never drops before done
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busLock && !done) |=> busLock);

  // R7: the sequence opens with a read
  a_r7_read_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busLock) |-> (memEn && !memWe));

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind atomic_rmw_unit atomic_rmw_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busLock (busLock),
  .done    (done),
  .memEn   (memEn),
  .memWe   (memWe)
);

// File: tb/atomic_rmw_unit_tb_top.sv
module atomic_rmw_unit_tb_top;

  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    opCode = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] srcLo = '0, srcHi = '0, cmpLo = '0, cmpHi = '0;
  logic [DW-1:0] memRdata;
  logic          memEn, memWe, busLock, done;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, srcOut, cmpOutLo, cmpOutHi;
  logic          flagCarry, flagZero, flagSign, flagOvf;

  int checks = 0;
  int fails  = 0;
  int lockViolations = 0;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic [3:0]    eFlags;  // {carry, zero, sign, ovf}

  always #5 clk = ~clk;

  atomic_rmw_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .addr(addr),
    .srcLo(srcLo), .srcHi(srcHi), .cmpLo(cmpLo), .cmpHi(cmpHi),
    .memRdata(memRdata), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .busLock(busLock), .done(done), .srcOut(srcOut),
    .cmpOutLo(cmpOutLo), .cmpOutHi(cmpOutHi), .flagCarry(flagCarry),
    .flagZero(flagZero), .flagSign(flagSign), .flagOvf(flagOvf)
  );

  function automatic logic [DW-1:0] initWord(input int i);
    return (DW'(i) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
  endfunction

  // bench memory: one-cycle read latency
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= initWord(i);
      memRdata <= '0;
    end else if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata <= mem[memAddr];
    end
  end

  always @(negedge clk) if (rstN && memEn && !busLock) lockViolations++;

  function automatic logic [3:0] addFlags(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return {s[DW], s[DW-1:0] == '0, s[DW-1],
            (a[DW-1] == b[DW-1]) && (s[DW-1] != a[DW-1])};
  endfunction

  function automatic logic [3:0] subFlags(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] d;
    d = {1'b0, a} - {1'b0, b};
    return {d[DW], d[DW-1:0] == '0, d[DW-1],
            (a[DW-1] != b[DW-1]) && (d[DW-1] != a[DW-1])};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] sL, input logic [DW-1:0] sH,
                       input logic [DW-1:0] cL, input logic [DW-1:0] cH,
                       input bit poke, input string req);
    logic [AW-1:0] a1;
    logic [DW-1:0] m0, m1, eSrc, eCL, eCH;
    int eLat, cyc;
    bit hit, memOk;
    a1 = a + 1'b1;
    m0 = shadow[a];
    m1 = shadow[a1];
    eSrc = sL; eCL = cL; eCH = cH; eLat = 4;
    case (op)
      2'd0: begin eSrc = m0; shadow[a] = sL; end
      2'd1: begin eSrc = m0; eFlags = addFlags(sL, m0); shadow[a] = sL + m0; end
      2'd2: begin
        eCL = m0; eFlags = subFlags(cL, m0);
        if (cL == m0) shadow[a] = sL; else eLat = 3;
      end
      default: begin
        eCL = m0; eCH = m1;
        hit = ({cH, cL} == {m1, m0});
        eFlags[2] = hit;
        if (hit) begin shadow[a] = sL; shadow[a1] = sH; eLat = 6; end
      end
    endcase
    @(negedge clk);
    opCode = op; addr = a; srcLo = sL; srcHi = sH; cmpLo = cL; cmpHi = cH;
    start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) begin
        start = 1'b1; opCode = 2'd0; addr = a + 4'd7; srcLo = 32'hDEADBEEF;
      end else if (!poke || cyc < 2) begin
        start = 1'b0;
      end
    end while (!done && cyc < 20);
    start = 1'b0;
    check(cyc == eLat, "R8", "done latency", 64'(cyc), 64'(eLat));
    check(srcOut == eSrc, req, "srcOut", 64'(srcOut), 64'(eSrc));
    check(cmpOutLo == eCL, req, "cmpOutLo", 64'(cmpOutLo), 64'(eCL));
    check(cmpOutHi == eCH, req, "cmpOutHi", 64'(cmpOutHi), 64'(eCH));
    check({flagCarry, flagZero, flagSign, flagOvf} == eFlags, req, "flags",
          64'({flagCarry, flagZero, flagSign, flagOvf}), 64'(eFlags));
    @(negedge clk);
    check(!busLock, "R7", "lock after done", 64'(busLock), 64'd0);
    memOk = 1'b1;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== shadow[i]) memOk = 1'b0;
    check(memOk, poke ? "R9" : req, "memory image", 64'(mem[a]), 64'(shadow[a]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [1:0] op;
    logic [AW-1:0] a;
    logic [DW-1:0] sL, sH, cL, cH;
    void'($urandom(32'd1234));
    eFlags = '0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = initWord(i);
    repeat (3) @(negedge clk);
    check(!busLock && !done && !memEn && !memWe, "R1", "control outputs",
          64'({busLock, done, memEn, memWe}), 64'd0);
    check(srcOut == '0 && cmpOutLo == '0 && cmpOutHi == '0, "R1", "register outputs",
          64'(srcOut | cmpOutLo | cmpOutHi), 64'd0);
    check({flagCarry, flagZero, flagSign, flagOvf} == 4'd0, "R1", "flags",
          64'({flagCarry, flagZero, flagSign, flagOvf}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busLock && !memEn, "R1", "idle after reset", 64'({busLock, memEn}), 64'd0);

    // directed corners
    runOp(2'd1, 4'd2, 32'h7FFFFFFF - shadow[2] + 32'h1, 0, 0, 0, 0, "R3"); // sum 0x80000000
    runOp(2'd1, 4'd3, 32'h0 - shadow[3], 0, 0, 0, 0, "R3");                // wraps to zero, carry
    runOp(2'd0, 4'd4, 32'h12345678, 0, 32'h1, 32'h2, 0, "R2");             // flags held
    runOp(2'd2, 4'd5, 32'hCAFEF00D, 0, shadow[5], 0, 0, "R4");
    runOp(2'd2, 4'd6, 32'h11111111, 0, 32'h0, 0, 0, "R5");                 // borrow
    runOp(2'd3, 4'd8, 32'hA0A0A0A0, 32'hB1B1B1B1, shadow[8], shadow[9], 0, "R6");
    runOp(2'd3, 4'd10, 32'h1, 32'h2, shadow[10], ~shadow[11], 0, "R6");    // high word differs
    runOp(2'd3, 4'd15, 32'h33, 32'h44, shadow[15], shadow[0], 0, "R6");    // wrap
    runOp(2'd0, 4'd1, 32'h55AA55AA, 0, 0, 0, 1, "R9");                     // start while busy
    runOp(2'd2, 4'd12, 32'h9, 0, shadow[12], 0, 1, "R9");

    for (int n = 0; n < 60; n++) begin
      op = 2'($urandom_range(0, 3));
      a  = AW'($urandom_range(0, DEPTH - 1));
      sL = $urandom; sH = $urandom; cL = $urandom; cH = $urandom;
      if ($urandom_range(0, 1) == 1) begin cL = shadow[a]; cH = shadow[a + 1'b1]; end
      case (op)
        2'd0: runOp(op, a, sL, sH, cL, cH, 0, "R2");
        2'd1: runOp(op, a, sL, sH, cL, cH, 0, "R3");
        2'd2: runOp(op, a, sL, sH, cL, cH, 0, (cL == shadow[a]) ? "R4" : "R5");
        default: runOp(op, a, sL, sH, cL, cH, 0, "R6");
      endcase
    end

    check(lockViolations == 0, "R7", "accesses outside lock", 64'(lockViolations), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule